// File: doc/BRIEF.md
# DMA Coherence Completion Tracker

This block carries a single DMA read or DMA write to a cacheable line from start to finish. When it accepts a request, it records the requestor, the byte offset, the byte count and the write bytes. In the next cycle it sends one probe to every cache. A DMA read asks the caches for a shared copy. A DMA write asks them to give up the line, and the block itself is the requestor. The block then counts one answer per cache. It collects line data from a cache holding dirty data or from memory, and a cache's dirty data always wins.

When the last awaited input arrives, the block finishes the transaction. For a read, it returns the whole line to the DMA requestor on the DMA response channel. For a write, it overlays the DMA bytes on the line, writes the result to memory and waits for the memory acknowledge before it sends a DMA ack. In each case it reports the directory state the line settles in. Only one transaction is active at a time. `dma_ready` stays low until the block returns to idle.

States: `ST_IDLE` goes to `ST_RD_GATHER` or `ST_WR_GATHER` on an accepted request. `ST_RD_GATHER` goes back to `ST_IDLE` on read completion. `ST_WR_GATHER` goes to `ST_WR_FLUSH` on write completion. `ST_WR_FLUSH` goes to `ST_IDLE` when the memory acknowledge arrives.

Top module: `dma_coh_tracker`

## Requirements
- R1: After reset, `dma_ready` is 1 and `probe_valid`, `mem_rd_valid`, `mem_wr_valid`, `dmar_valid` and `done_valid` are 0.
- R2: One cycle after a request is accepted (`dma_valid` and `dma_ready` high at a clock edge), `probe_valid` pulses for one cycle. In that cycle `probe_excl` is 1 for a write and 0 for a read, and `probe_addr` is `dma_addr` with its low 6 bits cleared. `dma_ready` then stays 0 until the transaction is released.
- R3: The block awaits exactly NUM_CACHES (default 4) cache answers on `rsp_valid`. Each answer counts as one, whatever its `rsp_kind`: 0 plain ack, 1 ack with shared copy, 2 shared data, 3 data.
- R4: A read whose `dma_line_state` is owner (1) or exclusive (2) raises `mem_rd_valid` in the same cycle as the probe. A read in not-owner (0), and any write, raises no memory read.
- R5: A data answer (kind 2 or 3) places `rsp_data` in the line buffer. Memory read data is kept only if no data answer has been received yet, so cache data wins in either arrival order.
- R6: A read that starts in state 0 or 2 completes one cycle after the later of its last cache answer and its memory data, if memory data is awaited. At completion, `dmar_valid` carries the buffered line to `dmar_dst` = `dma_src` with `dmar_is_ack` 0. `done_state` is 1 (owner) if any answer was of kind 1 or 2, and 2 (exclusive) otherwise.
- R7: For a read that starts in state 1, `dmar_valid` delivers the memory data one cycle after it arrives. Completion then raises `done_valid` with `done_state` 1 and no further DMA data.
- R8: On write completion, `mem_wr_valid` pulses one cycle after the last cache answer. Byte b of `mem_wdata` (bits 8b+7..8b) comes from `dma_wdata` when offset ≤ b < offset+`dma_len`, where offset is `dma_addr[5:0]`, and from the line buffer otherwise. `mem_wbe` is all ones if a data answer was received, and only the DMA bytes otherwise.
- R9: One cycle after `mem_wack` following a write, `dmar_valid` pulses with `dmar_is_ack` 1 to `dma_src`, and `done_state` is 2, even if caches reported shared copies.
- R10: `rsp_valid` and `mem_rdata_valid` are ignored while idle. They produce no output and do not change the answer count of the next transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_valid | input | 1 | DMA request present |
| dma_ready | output | 1 | Block idle and able to take a request |
| dma_is_write | input | 1 | 1 for a DMA write, 0 for a DMA read |
| dma_addr | input | ADDR_W | Physical address; low 6 bits are the byte offset |
| dma_len | input | 7 | Number of bytes to write |
| dma_wdata | input | 512 | Write bytes, laid out at their line positions |
| dma_src | input | SRC_W | Requestor identifier |
| dma_line_state | input | 2 | Directory state of the line at the request: 0 not owner, 1 owner, 2 exclusive |
| probe_valid | output | 1 | Broadcast probe to all caches |
| probe_excl | output | 1 | Probe asks for exclusive (1) or shared (0) |
| probe_addr | output | ADDR_W | Line address of the probe |
| rsp_valid | input | 1 | One cache answer |
| rsp_kind | input | 2 | Answer kind (0..3, see R3) |
| rsp_data | input | 512 | Line data for kinds 2 and 3 |
| mem_rd_valid | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Line address for memory reads and writes |
| mem_rdata_valid | input | 1 | Memory read data present |
| mem_rdata | input | 512 | Memory read data |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wdata | output | 512 | Merged line to write |
| mem_wbe | output | 64 | Byte enables for the write |
| mem_wack | input | 1 | Memory write acknowledge |
| dmar_valid | output | 1 | DMA response |
| dmar_is_ack | output | 1 | 1 for a write ack, 0 for line data |
| dmar_dst | output | SRC_W | Requestor the response goes to |
| dmar_data | output | 512 | Line data for a read |
| done_valid | output | 1 | Transaction released |
| done_state | output | 2 | Final directory state (1 owner, 2 exclusive) |

## Verification
A miscounted answer shifts the cycle in which `dmar_valid`, `mem_wr_valid` or `done_valid` appears, or suppresses it altogether. The scoreboard therefore checks each output's cycle as well as its content. A lost sharer or dirty flag appears at completion, as the wrong `done_state`, the wrong line (memory data where cache data was due) or a full-versus-partial `mem_wbe` mismatch. A wrong offset or length shows in the merged bytes in the single cycle `mem_wr_valid` is high. Every such fault reaches the ports no later than the completing cycle of the transaction that exposed it.

// File: rtl/dct_pkg.sv
package dct_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_RD_GATHER = 2'd1,
        ST_WR_GATHER = 2'd2,
        ST_WR_FLUSH  = 2'd3
    } trk_state_t;

    typedef enum logic [1:0] {
        LS_NOT_OWNER = 2'd0,
        LS_OWNER     = 2'd1,
        LS_EXCL      = 2'd2,
        LS_RSVD      = 2'd3
    } line_state_t;

    typedef enum logic [1:0] {
        RK_ACK      = 2'd0,
        RK_ACK_SH   = 2'd1,
        RK_DATA_SH  = 2'd2,
        RK_DATA     = 2'd3
    } rsp_kind_t;

endpackage

// File: rtl/dct_resp_tally.sv
module dct_resp_tally
    import dct_pkg::*;
#(
    parameter int NUM_CACHES = 4,
    parameter int CNT_W      = $clog2(NUM_CACHES + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       rsp_fire,
    input  logic [1:0] rsp_kind,
    output logic       zero_nxt,
    output logic       sharer_nxt,
    output logic       dirty_nxt,
    output logic       data_hit
);

    logic [CNT_W-1:0] cnt_q, cnt_nxt;
    logic             sharer_q, dirty_q;
    rsp_kind_t        kind;

    assign kind     = rsp_kind_t'(rsp_kind);
    assign data_hit = rsp_fire && (kind == RK_DATA_SH || kind == RK_DATA);

    always_comb begin
        cnt_nxt    = cnt_q;
        sharer_nxt = sharer_q;
        dirty_nxt  = dirty_q;
        if (load) begin
            cnt_nxt    = CNT_W'(NUM_CACHES);
            sharer_nxt = 1'b0;
            dirty_nxt  = 1'b0;
        end else if (rsp_fire) begin
            cnt_nxt = cnt_q - CNT_W'(1);
            if (kind == RK_ACK_SH || kind == RK_DATA_SH) sharer_nxt = 1'b1;
            if (data_hit) dirty_nxt = 1'b1;
        end
    end

    assign zero_nxt = (cnt_nxt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            sharer_q <= 1'b0;
            dirty_q  <= 1'b0;
        end else begin
            cnt_q    <= cnt_nxt;
            sharer_q <= sharer_nxt;
            dirty_q  <= dirty_nxt;
        end
    end

    // R3: an answer never arrives while the count is already exhausted
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fire |-> cnt_q != '0);
    // R3: a new transaction awaits every cache
    p_load_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == CNT_W'(NUM_CACHES));
    // R5: once cache data is held it stays held until the next request
    p_dirty_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty_q && !load) |=> dirty_q);

endmodule

// File: rtl/dct_byte_merge.sv
module dct_byte_merge #(
    parameter int LINE_BYTES = 64,
    parameter int OFF_W      = $clog2(LINE_BYTES),
    parameter int LEN_W      = OFF_W + 1
) (
    input  logic [LINE_BYTES*8-1:0] base,
    input  logic [LINE_BYTES*8-1:0] patch,
    input  logic [OFF_W-1:0]        off,
    input  logic [LEN_W-1:0]        len,
    output logic [LINE_BYTES*8-1:0] merged,
    output logic [LINE_BYTES-1:0]   be
);

    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
        assign be[b] = (int'(off) <= b) && (b < int'(off) + int'(len));
        assign merged[b*8 +: 8] = be[b] ? patch[b*8 +: 8] : base[b*8 +: 8];
    end

endmodule

// File: rtl/dma_coh_tracker.sv
module dma_coh_tracker
    import dct_pkg::*;
#(
    parameter int NUM_CACHES = 4,
    parameter int LINE_BYTES = 64,
    parameter int ADDR_W     = 32,
    parameter int SRC_W      = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    dma_valid,
    output logic                    dma_ready,
    input  logic                    dma_is_write,
    input  logic [ADDR_W-1:0]       dma_addr,
    input  logic [$clog2(LINE_BYTES):0] dma_len,
    input  logic [LINE_BYTES*8-1:0] dma_wdata,
    input  logic [SRC_W-1:0]        dma_src,
    input  logic [1:0]              dma_line_state,
    output logic                    probe_valid,
    output logic                    probe_excl,
    output logic [ADDR_W-1:0]       probe_addr,
    input  logic                    rsp_valid,
    input  logic [1:0]              rsp_kind,
    input  logic [LINE_BYTES*8-1:0] rsp_data,
    output logic                    mem_rd_valid,
    output logic [ADDR_W-1:0]       mem_addr,
    input  logic                    mem_rdata_valid,
    input  logic [LINE_BYTES*8-1:0] mem_rdata,
    output logic                    mem_wr_valid,
    output logic [LINE_BYTES*8-1:0] mem_wdata,
    output logic [LINE_BYTES-1:0]   mem_wbe,
    input  logic                    mem_wack,
    output logic                    dmar_valid,
    output logic                    dmar_is_ack,
    output logic [SRC_W-1:0]        dmar_dst,
    output logic [LINE_BYTES*8-1:0] dmar_data,
    output logic                    done_valid,
    output logic [1:0]              done_state
);

    localparam int LINE_W = LINE_BYTES * 8;
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int LEN_W  = OFF_W + 1;

    trk_state_t         state_q, state_nxt;
    line_state_t        start_ls;
    logic               accept, rsp_fire, mem_fire, early_fwd;
    logic               rd_done, wr_done, wack_ev;
    logic               zero_nxt, sharer_nxt, dirty_nxt, data_hit;
    logic               mem_pend_q, mem_pend_nxt, from_owner_q;
    logic [ADDR_W-1:0]  line_q;
    logic [OFF_W-1:0]   off_q;
    logic [LEN_W-1:0]   len_q;
    logic [SRC_W-1:0]   src_q;
    logic [LINE_W-1:0]  wdata_q, buf_q, buf_nxt, merged;
    logic [LINE_BYTES-1:0] patch_be;

    assign start_ls  = line_state_t'(dma_line_state);
    assign dma_ready = (state_q == ST_IDLE);
    assign accept    = dma_valid && dma_ready;
    assign rsp_fire  = rsp_valid && (state_q == ST_RD_GATHER || state_q == ST_WR_GATHER);
    assign mem_fire  = mem_rdata_valid && mem_pend_q && (state_q == ST_RD_GATHER);
    assign mem_pend_nxt = mem_pend_q && !mem_fire;
    assign early_fwd = mem_fire && from_owner_q;
    assign rd_done   = (state_q == ST_RD_GATHER) && (rsp_fire || mem_fire)
                       && zero_nxt && !mem_pend_nxt;
    assign wr_done   = (state_q == ST_WR_GATHER) && rsp_fire && zero_nxt;
    assign wack_ev   = (state_q == ST_WR_FLUSH) && mem_wack;

    assign probe_addr = line_q;
    assign mem_addr   = line_q;

    dct_resp_tally #(.NUM_CACHES(NUM_CACHES)) u_tally (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .rsp_fire   (rsp_fire),
        .rsp_kind   (rsp_kind),
        .zero_nxt   (zero_nxt),
        .sharer_nxt (sharer_nxt),
        .dirty_nxt  (dirty_nxt),
        .data_hit   (data_hit)
    );

    always_comb begin
        buf_nxt = buf_q;
        if (data_hit)                    buf_nxt = rsp_data;
        else if (mem_fire && !dirty_nxt) buf_nxt = mem_rdata;
    end

    dct_byte_merge #(.LINE_BYTES(LINE_BYTES)) u_merge (
        .base   (buf_nxt),
        .patch  (wdata_q),
        .off    (off_q),
        .len    (len_q),
        .merged (merged),
        .be     (patch_be)
    );

    // next-state decision
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE:      if (accept) state_nxt = dma_is_write ? ST_WR_GATHER : ST_RD_GATHER;
            ST_RD_GATHER: if (rd_done) state_nxt = ST_IDLE;
            ST_WR_GATHER: if (wr_done) state_nxt = ST_WR_FLUSH;
            ST_WR_FLUSH:  if (wack_ev) state_nxt = ST_IDLE;
            default:      state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nxt;
    end

    // transaction record and line buffer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q       <= '0;
            off_q        <= '0;
            len_q        <= '0;
            src_q        <= '0;
            wdata_q      <= '0;
            buf_q        <= '0;
            mem_pend_q   <= 1'b0;
            from_owner_q <= 1'b0;
        end else if (accept) begin
            line_q       <= {dma_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            off_q        <= dma_addr[OFF_W-1:0];
            len_q        <= dma_len;
            src_q        <= dma_src;
            wdata_q      <= dma_wdata;
            mem_pend_q   <= !dma_is_write && (start_ls != LS_NOT_OWNER);
            from_owner_q <= !dma_is_write && (start_ls == LS_OWNER);
        end else begin
            buf_q      <= buf_nxt;
            mem_pend_q <= mem_pend_nxt;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            probe_valid  <= 1'b0;
            probe_excl   <= 1'b0;
            mem_rd_valid <= 1'b0;
            mem_wr_valid <= 1'b0;
            mem_wdata    <= '0;
            mem_wbe      <= '0;
            dmar_valid   <= 1'b0;
            dmar_is_ack  <= 1'b0;
            dmar_dst     <= '0;
            dmar_data    <= '0;
            done_valid   <= 1'b0;
            done_state   <= LS_NOT_OWNER;
        end else begin
            probe_valid  <= accept;
            probe_excl   <= accept && dma_is_write;
            mem_rd_valid <= accept && !dma_is_write && (start_ls != LS_NOT_OWNER);
            mem_wr_valid <= wr_done;
            mem_wdata    <= merged;
            mem_wbe      <= dirty_nxt ? '1 : patch_be;
            dmar_valid   <= early_fwd || (rd_done && !from_owner_q) || wack_ev;
            dmar_is_ack  <= wack_ev;
            dmar_dst     <= src_q;
            dmar_data    <= early_fwd ? mem_rdata : buf_nxt;
            done_valid   <= rd_done || wack_ev;
            done_state   <= (!wack_ev && (from_owner_q || sharer_nxt)) ? LS_OWNER : LS_EXCL;
        end
    end

    // R2: acceptance drops ready and launches the probe
    p_ready_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !dma_ready && probe_valid);
    // R4: a read of a not-owned line fetches nothing from memory
    p_no_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !dma_is_write && start_ls == LS_NOT_OWNER) |=> !mem_rd_valid);
    // R6: a released transaction always reports owner or exclusive
    p_done_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (done_state == LS_OWNER || done_state == LS_EXCL));
    // R8: the requested span fits inside the line
    p_span_fits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (int'(dma_addr[OFF_W-1:0]) + int'(dma_len) <= LINE_BYTES));
    // R9: memory acknowledge turns into a DMA ack and exclusive state
    p_flush_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wack_ev |=> dmar_valid && dmar_is_ack && done_state == LS_EXCL);

endmodule

// File: tb/dma_coh_tracker_tb_top.sv
module dma_coh_tracker_tb_top;

    localparam int NC = 4;
    localparam int LB = 64;
    localparam int LW = LB * 8;
    localparam int AW = 32;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          dma_valid, dma_ready, dma_is_write;
    logic [AW-1:0] dma_addr;
    logic [6:0]    dma_len;
    logic [LW-1:0] dma_wdata;
    logic [SW-1:0] dma_src;
    logic [1:0]    dma_line_state;
    logic          probe_valid, probe_excl;
    logic [AW-1:0] probe_addr;
    logic          rsp_valid;
    logic [1:0]    rsp_kind;
    logic [LW-1:0] rsp_data;
    logic          mem_rd_valid;
    logic [AW-1:0] mem_addr;
    logic          mem_rdata_valid;
    logic [LW-1:0] mem_rdata;
    logic          mem_wr_valid;
    logic [LW-1:0] mem_wdata;
    logic [LB-1:0] mem_wbe;
    logic          mem_wack;
    logic          dmar_valid, dmar_is_ack;
    logic [SW-1:0] dmar_dst;
    logic [LW-1:0] dmar_data;
    logic          done_valid;
    logic [1:0]    done_state;

    always #2 clk = ~clk;

    dma_coh_tracker dut_i (
        .clk(clk), .rst_n(rst_n),
        .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_is_write(dma_is_write),
        .dma_addr(dma_addr), .dma_len(dma_len), .dma_wdata(dma_wdata),
        .dma_src(dma_src), .dma_line_state(dma_line_state),
        .probe_valid(probe_valid), .probe_excl(probe_excl), .probe_addr(probe_addr),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_data(rsp_data),
        .mem_rd_valid(mem_rd_valid), .mem_addr(mem_addr),
        .mem_rdata_valid(mem_rdata_valid), .mem_rdata(mem_rdata),
        .mem_wr_valid(mem_wr_valid), .mem_wdata(mem_wdata), .mem_wbe(mem_wbe),
        .mem_wack(mem_wack),
        .dmar_valid(dmar_valid), .dmar_is_ack(dmar_is_ack), .dmar_dst(dmar_dst),
        .dmar_data(dmar_data), .done_valid(done_valid), .done_state(done_state)
    );

    typedef struct {
        string         tag;
        int            cyc;
        bit            dmar;
        bit            ack;
        logic [LW-1:0] ddata;
        logic [SW-1:0] dst;
        bit            done;
        logic [1:0]    st;
        bit            mw;
        logic [LW-1:0] wdata;
        logic [LB-1:0] be;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_vec = 0;
    int   n_bad = 0;
    bit   finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [LW-1:0] pat(int seed);
        logic [LW-1:0] r;
        for (int k = 0; k < LW / 32; k++)
            r[k*32 +: 32] = (32'(seed) * 32'h0100_0193) ^ (32'(k) * 32'h9E37_79B9) ^ 32'h5A5A_0000;
        return r;
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && (dmar_valid || done_valid || mem_wr_valid)) begin
            n_vec++;
            if (q.size() == 0) begin
                n_bad++;
                $display("FAIL R10 unexpected output actual=dmar%0b done%0b mw%0b expected=none",
                         dmar_valid, done_valid, mem_wr_valid);
            end else begin
                exp_t e;
                logic [LW-1:0] mask;
                bit ok;
                e = q.pop_front();
                for (int b = 0; b < LB; b++) mask[b*8 +: 8] = {8{e.be[b]}};
                ok = (cyc == e.cyc) && (dmar_valid == e.dmar) && (done_valid == e.done)
                     && (mem_wr_valid == e.mw);
                if (e.dmar) ok = ok && (dmar_is_ack == e.ack) && (dmar_dst == e.dst)
                                 && (e.ack || dmar_data == e.ddata);
                if (e.done) ok = ok && (done_state == e.st);
                if (e.mw)   ok = ok && (mem_wbe == e.be)
                                 && ((mem_wdata & mask) == (e.wdata & mask));
                if (!ok) begin
                    n_bad++;
                    $display("FAIL %s actual=cyc%0d dmar%0b ack%0b d%0h done%0b st%0d mw%0b w%0h be%0h expected=cyc%0d dmar%0b ack%0b d%0h done%0b st%0d mw%0b w%0h be%0h",
                             e.tag, cyc, dmar_valid, dmar_is_ack, dmar_data[31:0], done_valid,
                             done_state, mem_wr_valid, mem_wdata[31:0], mem_wbe,
                             e.cyc, e.dmar, e.ack, e.ddata[31:0], e.done, e.st, e.mw,
                             e.wdata[31:0], e.be);
                end
            end
        end
    end

    function automatic exp_t blank(string tag, int c);
        exp_t e;
        e.tag = tag; e.cyc = c; e.dmar = 0; e.ack = 0; e.ddata = '0; e.dst = '0;
        e.done = 0; e.st = 2'd0; e.mw = 0; e.wdata = '0; e.be = '0;
        return e;
    endfunction

    // driver: one transaction, expected items pushed before the edge that makes them
    task automatic txn(string tag, bit wr, logic [1:0] st, int off, int len,
                       logic [SW-1:0] src, int kinds[NC], int mem_pos, int seed);
        logic [LW-1:0] bufm, wd, md;
        logic [AW-1:0] addr;
        bit need_mem, pend, dirty, sharer, from_o;
        int cnt;
        exp_t e;
        addr = 32'h8000_0000 | (32'(seed) << 6) | 32'(off);
        wd   = pat(seed + 500);
        md   = pat(seed + 100);
        bufm = '0;
        dma_valid = 1; dma_is_write = wr; dma_addr = addr; dma_len = 7'(len);
        dma_wdata = wd; dma_src = src; dma_line_state = st;
        @(posedge clk); #1;
        dma_valid = 0;
        chk(probe_valid == 1'b1, {tag, " R2 probe pulse"}, 64'(probe_valid), 64'd1);
        chk(probe_excl == wr, {tag, " R2 probe kind"}, 64'(probe_excl), 64'(wr));
        chk(probe_addr == (addr & ~32'h3F), {tag, " R2 probe addr"}, 64'(probe_addr), 64'(addr & ~32'h3F));
        chk(dma_ready == 1'b0, {tag, " R2 ready low"}, 64'(dma_ready), 64'd0);
        need_mem = !wr && (st != 2'd0);
        chk(mem_rd_valid == need_mem, {tag, " R4 mem read"}, 64'(mem_rd_valid), 64'(need_mem));
        pend = need_mem; dirty = 0; sharer = 0; from_o = !wr && (st == 2'd1); cnt = NC;
        for (int s = 0; s <= NC; s++) begin
            for (int ph = 0; ph < 2; ph++) begin
                bit is_mem, fire, early, compl;
                is_mem = (ph == 0);
                fire = is_mem ? (need_mem && s == mem_pos) : (s < NC);
                if (fire) begin
                    early = 0;
                    if (is_mem) begin
                        mem_rdata_valid = 1; mem_rdata = md;
                        if (!dirty) bufm = md;
                        pend = 0;
                        early = from_o;
                    end else begin
                        rsp_valid = 1; rsp_kind = 2'(kinds[s]); rsp_data = pat(seed + s);
                        cnt--;
                        if (kinds[s] == 1 || kinds[s] == 2) sharer = 1;
                        if (kinds[s] >= 2) begin dirty = 1; bufm = pat(seed + s); end
                    end
                    compl = (cnt == 0) && !pend;
                    e = blank({tag, wr ? " R8" : (from_o ? " R7" : " R6")}, cyc + 1);
                    if (early) begin e.dmar = 1; e.ddata = md; e.dst = src; end
                    if (compl && !wr) begin
                        e.done = 1;
                        e.st = (from_o || sharer) ? 2'd1 : 2'd2;
                        if (!from_o) begin e.dmar = 1; e.ddata = bufm; e.dst = src; end
                    end
                    if (compl && wr) begin
                        e.mw = 1;
                        for (int b = 0; b < LB; b++) begin
                            bit en;
                            en = (b >= off) && (b < off + len);
                            e.wdata[b*8 +: 8] = en ? wd[b*8 +: 8] : bufm[b*8 +: 8];
                            e.be[b] = dirty ? 1'b1 : en;
                        end
                    end
                    if (e.dmar || e.done || e.mw) q.push_back(e);
                    @(posedge clk); #1;
                    mem_rdata_valid = 0; rsp_valid = 0;
                end
            end
        end
        if (wr) begin
            @(posedge clk); #1;
            @(posedge clk); #1;
            mem_wack = 1;
            e = blank({tag, " R9 write ack"}, cyc + 1);
            e.dmar = 1; e.ack = 1; e.dst = src; e.done = 1; e.st = 2'd2;
            q.push_back(e);
            @(posedge clk); #1;
            mem_wack = 0;
        end
        @(posedge clk); #1;
        chk(dma_ready == 1'b1, {tag, " R2 ready back"}, 64'(dma_ready), 64'd1);
        @(posedge clk); #1;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #600000;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        rst_n = 0; dma_valid = 0; dma_is_write = 0; dma_addr = '0; dma_len = '0;
        dma_wdata = '0; dma_src = '0; dma_line_state = 2'd0;
        rsp_valid = 0; rsp_kind = 2'd0; rsp_data = '0;
        mem_rdata_valid = 0; mem_rdata = '0; mem_wack = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(posedge clk); #1;
        // R1 reset state
        chk(dma_ready == 1'b1, "R1 ready", 64'(dma_ready), 64'd1);
        chk({probe_valid, mem_rd_valid, mem_wr_valid, dmar_valid, done_valid} == 5'b0,
            "R1 outputs quiet", 64'({probe_valid, mem_rd_valid, mem_wr_valid, dmar_valid, done_valid}), 64'd0);

        txn("E read acks, mem mid", 0, 2'd2, 0, 0, 4'd3, '{0, 0, 0, 0}, 2, 10);
        txn("E read shared, mem last", 0, 2'd2, 0, 0, 4'd5, '{0, 1, 0, 0}, 4, 20);
        txn("NO read dirty cache", 0, 2'd0, 0, 0, 4'd1, '{0, 3, 0, 0}, 9, 30);
        txn("NO read shared data", 0, 2'd0, 0, 0, 4'd2, '{2, 0, 1, 0}, 9, 40);
        // R5: cache data before memory data, then memory data before cache data
        txn("R5 cache first", 0, 2'd2, 0, 0, 4'd6, '{3, 0, 0, 0}, 3, 50);
        txn("R5 mem first", 0, 2'd2, 0, 0, 4'd7, '{0, 0, 3, 0}, 0, 60);
        txn("O read early fwd", 0, 2'd1, 0, 0, 4'd8, '{0, 0, 0, 0}, 1, 70);
        txn("O read mem last", 0, 2'd1, 0, 0, 4'd9, '{1, 0, 0, 0}, 4, 80);

        // R10: stray answer and memory data while idle
        rsp_valid = 1; rsp_kind = 2'd3; rsp_data = pat(999); mem_rdata_valid = 1;
        @(posedge clk); #1;
        rsp_valid = 0; mem_rdata_valid = 0;
        @(posedge clk); #1;
        chk(dma_ready == 1'b1, "R10 still idle", 64'(dma_ready), 64'd1);

        txn("R10 clean write after stray", 1, 2'd0, 5, 10, 4'd4, '{0, 0, 0, 0}, 9, 90);
        txn("write dirty tail bytes", 1, 2'd2, 60, 4, 4'd10, '{0, 0, 3, 0}, 9, 100);
        txn("write full line sharers", 1, 2'd1, 0, 64, 4'd11, '{1, 0, 2, 0}, 9, 110);

        repeat (4) @(posedge clk);
        #1;
        chk(q.size() == 0, "R6 all expected outputs seen", 64'(q.size()), 64'd0);
        summary();
    end

endmodule